// File: doc/BRIEF.md
# Converter link transmit bring-up sequencer

This block is the transmit-side control state machine of a multi-gigabit converter link. After reset it holds the link in code-group synchronization. The receiver releases its active-low synchronization request when it is ready. The sequencer then moves either to the initial lane alignment phase or straight to user data. Entry into alignment is set by a lane-alignment enable. Deterministic-latency operation needs extra gating. In subclass 1 the exit waits for a sampled rising edge of the system reference. In subclass 2 the sequencer records where the request was released relative to its local multiframe clock.

While the link runs, the sequencer watches the receiver's request line. If the request stays asserted longer than five frames plus nine octets, the link drops back to synchronization. This hardware restart can be disabled. Software can force a restart at any time. After a software restart, the sequencer waits for the receiver to assert the request again before it accepts a release. One octet is processed per link clock. Character generation, scrambling and serialization live in neighbouring blocks that decode the phase output.

Top module: `lnk_tx_startup_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `phase_o` is 0 (synchronization), `lmfc_offset_o` is 0 and `reinit_evt_o` is 0. The phase encoding is 0 = synchronization, 1 = lane alignment, 2 = user data.
- R2: For subclass codes 0, 2 and 3, a release of `sync_n_i` is seen after a two-flop synchronizer. The sequencer then leaves synchronization on the third rising edge after the first edge that samples `sync_n_i` high. It goes to phase 1 when `lane_sync_en_i` is 1 and to phase 2 when it is 0.
- R3: For subclass code 1, synchronization is left only after a synchronized rising edge of `sysref_i` has been seen since the last reset or restart. This also holds when `sync_n_i` was released before that edge.
- R4: For subclass code 2, the release of `sync_n_i` during synchronization loads `lmfc_offset_o`. The value is the number of clock edges from the edge that sampled the last `lmfc_tick_i` to the first edge that sampled `sync_n_i` high, plus one. For other subclass codes the register keeps its value.
- R5: Outside synchronization, a restart happens when the synchronized `sync_n_i` is low for more than 5*F+9 consecutive cycles, where F is `frame_octets_i`. A low run of exactly 5*F+9 cycles does not restart the link.
- R6: The low-run count restarts from zero whenever the synchronized `sync_n_i` is high, so separate short low runs do not add up.
- R7: With `hw_reinit_dis_i` at 1, a low run of any length causes no restart and no event.
- R8: A `sw_reinit_req_i` sampled high forces phase 0 on that edge, whatever the state of `hw_reinit_dis_i`. Synchronization is then left only after `sync_n_i` has been seen low and then high again.
- R9: Lane alignment lasts exactly four `lmfc_tick_i` pulses. The phase becomes 2 on the edge that samples the fourth pulse.
- R10: `reinit_evt_o` is high for exactly one cycle for each restart, hardware or software, and is aligned with the return to phase 0.
- R11: A restart clears the record of a seen reference edge, so in subclass 1 a fresh reference edge is needed after every restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one octet per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sync_n_i | input | 1 | Receiver synchronization request, active low, asynchronous |
| sysref_i | input | 1 | System reference, asynchronous |
| subclass_i | input | 2 | Subclass code 0..3 |
| lane_sync_en_i | input | 1 | 1 = run lane alignment before data |
| frame_octets_i | input | FW (5) | Octets per frame F |
| hw_reinit_dis_i | input | 1 | 1 = block restarts caused by request timing |
| sw_reinit_req_i | input | 1 | Software restart request, sampled each cycle |
| lmfc_tick_i | input | 1 | Local multiframe boundary pulse |
| phase_o | output | 2 | Current phase: 0 sync, 1 alignment, 2 data |
| lmfc_offset_o | output | OW (8) | Captured release-to-multiframe offset |
| reinit_evt_o | output | 1 | One-cycle restart event |

## Verification
A wrong phase register shows on `phase_o` within the three-cycle synchronizer latency of a release. A stale reference-seen flag shows as a subclass 1 link that leaves synchronization after a restart with no new reference edge. An off-by-one in the low-run counter can only be seen at the 5*F+9 boundary. The bench therefore drives runs of exactly that length and one cycle longer. A corrupted multiframe position counter shows only in `lmfc_offset_o`, and only on a subclass 2 release. Two different release delays are used so that a constant error cannot go unnoticed.

// File: rtl/lnk_start_pkg.sv
package lnk_start_pkg;

    typedef enum logic [1:0] {
        PH_CGS  = 2'd0,
        PH_ILAS = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Synchronized view of the two asynchronous link lines
    typedef struct packed {
        logic sync_n;
        logic sysref;
    } line_t;

    // Restart causes evaluated in one cycle
    typedef struct packed {
        logic hw;
        logic sw;
    } reinit_t;

    // Longest tolerated request run in octets: five frames plus nine
    function automatic int hold_limit(input int frame_octets);
        return 5 * frame_octets + 9;
    endfunction

    // Only subclass 1 gates the exit on a reference edge
    function automatic logic needs_sysref(input logic [1:0] subclass);
        return subclass == 2'd1;
    endfunction

    function automatic logic captures_phase(input logic [1:0] subclass);
        return subclass == 2'd2;
    endfunction

endpackage

// File: rtl/lnk_sync2.sv
module lnk_sync2 #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[b] <= RST_VAL[b];
                stab_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= d_i[b];
                stab_q[b] <= meta_q[b];
            end
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/lnk_hold_timer.sv
module lnk_hold_timer
    import lnk_start_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_low_i,
    input  logic [FW-1:0] frame_octets_i,
    output logic          expire_o
);
    localparam int MAX_LIMIT = 5 * ((1 << FW) - 1) + 9;
    localparam int CW        = $clog2(MAX_LIMIT + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = CW'(hold_limit(int'(frame_octets_i)));

    // cnt_q holds the number of earlier consecutive low cycles
    always_ff @(posedge clk) begin
        if (rst || !sync_low_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires on the (limit+1)-th consecutive low cycle
    assign expire_o = sync_low_i && (cnt_q >= limit);

    p_run_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !sync_low_i |=> (cnt_q == '0));

    p_no_fire_high_r5: assert property (@(posedge clk) disable iff (rst)
        !sync_low_i |-> !expire_o);

endmodule

// File: rtl/lnk_lmfc_capture.sv
module lnk_lmfc_capture #(
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lmfc_tick_i,
    input  logic          cap_en_i,
    output logic [OW-1:0] offset_o
);
    logic [OW-1:0] pos_q;
    logic [OW-1:0] off_q;

    // Cycles since the last multiframe boundary, saturating
    always_ff @(posedge clk) begin
        if (rst || lmfc_tick_i) begin
            pos_q <= '0;
        end else if (pos_q != '1) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (cap_en_i) begin
            off_q <= pos_q;
        end
    end

    assign offset_o = off_q;

    p_hold_offset_r4: assert property (@(posedge clk) disable iff (rst)
        !cap_en_i |=> $stable(off_q));

endmodule

// File: rtl/lnk_tx_startup_ctrl.sv
module lnk_tx_startup_ctrl
    import lnk_start_pkg::*;
#(
    parameter int FW      = 5,
    parameter int OW      = 8,
    parameter int ILAS_MF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_n_i,
    input  logic          sysref_i,
    input  logic [1:0]    subclass_i,
    input  logic          lane_sync_en_i,
    input  logic [FW-1:0] frame_octets_i,
    input  logic          hw_reinit_dis_i,
    input  logic          sw_reinit_req_i,
    input  logic          lmfc_tick_i,
    output logic [1:0]    phase_o,
    output logic [OW-1:0] lmfc_offset_o,
    output logic          reinit_evt_o
);
    localparam int MCW = $clog2(ILAS_MF + 1);

    line_t     raw_lines;
    line_t     lines;
    reinit_t   req;
    phase_e    phase_q;
    phase_e    phase_d;
    logic      sync_prev_q;
    logic      sysref_prev_q;
    logic      sysref_seen_q;
    logic      wait_low_q;
    logic      evt_q;
    logic      hw_expire;
    logic      any_reinit;
    logic      cgs_exit;
    logic      sync_rise;
    logic      cap_en;
    logic [MCW-1:0] ilas_cnt_q;

    assign raw_lines = '{sync_n: sync_n_i, sysref: sysref_i};

    lnk_sync2 #(
        .W       (2),
        .RST_VAL (2'b00)
    ) line_sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (raw_lines),
        .q_o (lines)
    );

    lnk_hold_timer #(
        .FW (FW)
    ) hold_timer_i (
        .clk            (clk),
        .rst            (rst),
        .sync_low_i     (!lines.sync_n),
        .frame_octets_i (frame_octets_i),
        .expire_o       (hw_expire)
    );

    assign sync_rise = lines.sync_n && !sync_prev_q;
    assign cap_en    = sync_rise && (phase_q == PH_CGS) && captures_phase(subclass_i);

    lnk_lmfc_capture #(
        .OW (OW)
    ) lmfc_cap_i (
        .clk         (clk),
        .rst         (rst),
        .lmfc_tick_i (lmfc_tick_i),
        .cap_en_i    (cap_en),
        .offset_o    (lmfc_offset_o)
    );

    // Restart causes: timing-based only once the link has left sync
    assign req.hw     = hw_expire && (phase_q != PH_CGS) && !hw_reinit_dis_i;
    assign req.sw     = sw_reinit_req_i;
    assign any_reinit = req.hw || req.sw;

    assign cgs_exit = lines.sync_n && !wait_low_q &&
                      (!needs_sysref(subclass_i) || sysref_seen_q);

    always_comb begin
        phase_d = phase_q;
        if (any_reinit) begin
            phase_d = PH_CGS;
        end else begin
            case (phase_q)
                PH_CGS: begin
                    if (cgs_exit) begin
                        phase_d = lane_sync_en_i ? PH_ILAS : PH_DATA;
                    end
                end
                PH_ILAS: begin
                    if (lmfc_tick_i && (ilas_cnt_q == MCW'(ILAS_MF - 1))) begin
                        phase_d = PH_DATA;
                    end
                end
                default: phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q       <= PH_CGS;
            sync_prev_q   <= 1'b0;
            sysref_prev_q <= 1'b0;
            sysref_seen_q <= 1'b0;
            wait_low_q    <= 1'b0;
            evt_q         <= 1'b0;
            ilas_cnt_q    <= '0;
        end else begin
            phase_q       <= phase_d;
            sync_prev_q   <= lines.sync_n;
            sysref_prev_q <= lines.sysref;
            evt_q         <= any_reinit;

            if (any_reinit) begin
                sysref_seen_q <= 1'b0;
            end else if (lines.sysref && !sysref_prev_q) begin
                sysref_seen_q <= 1'b1;
            end

            if (req.sw) begin
                wait_low_q <= 1'b1;
            end else if (!lines.sync_n) begin
                wait_low_q <= 1'b0;
            end

            if (phase_q != PH_ILAS) begin
                ilas_cnt_q <= '0;
            end else if (lmfc_tick_i) begin
                ilas_cnt_q <= ilas_cnt_q + 1'b1;
            end
        end
    end

    assign phase_o      = phase_q;
    assign reinit_evt_o = evt_q;

    p_sc1_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CGS && subclass_i == 2'd1 && !sysref_seen_q) |=> (phase_q == PH_CGS));

    p_hw_block_r7: assert property (@(posedge clk) disable iff (rst)
        (hw_reinit_dis_i && !sw_reinit_req_i) |=> !reinit_evt_o);

    p_wait_low_r8: assert property (@(posedge clk) disable iff (rst)
        wait_low_q |-> (phase_q == PH_CGS));

    p_ilas_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ILAS && !lmfc_tick_i && !sw_reinit_req_i && !hw_expire)
        |=> (phase_q == PH_ILAS));

    p_evt_with_cgs_r10: assert property (@(posedge clk) disable iff (rst)
        reinit_evt_o |-> (phase_q == PH_CGS));

    p_legal_phase_r2: assert property (@(posedge clk) disable iff (rst)
        phase_q != 2'd3);

endmodule

// File: tb/lnk_tx_startup_ctrl_tb_top.sv
module lnk_tx_startup_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 5;
    localparam int OW = 8;

    typedef struct packed {
        logic [1:0] sc;
        logic       lse;
        logic       ref_pulse;
        logic [1:0] exp_phase;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 2'd1},
        '{2'd0, 1'b0, 1'b0, 2'd2},
        '{2'd1, 1'b1, 1'b0, 2'd0},
        '{2'd1, 1'b1, 1'b1, 2'd1},
        '{2'd1, 1'b0, 1'b1, 2'd2},
        '{2'd2, 1'b1, 1'b0, 2'd1},
        '{2'd2, 1'b0, 1'b0, 2'd2},
        '{2'd3, 1'b0, 1'b0, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_n = 1'b0;
    logic          sysref = 1'b0;
    logic [1:0]    subclass = 2'd0;
    logic          lane_sync_en = 1'b0;
    logic [FW-1:0] frame_octets = FW'(2);
    logic          hw_dis = 1'b0;
    logic          sw_req = 1'b0;
    logic          lmfc_tick = 1'b0;
    logic [1:0]    phase;
    logic [OW-1:0] offset;
    logic          evt;

    int n_checks = 0;
    int n_fail   = 0;
    int evt_cnt  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lnk_tx_startup_ctrl #(.FW(FW), .OW(OW), .ILAS_MF(4)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .sync_n_i        (sync_n),
        .sysref_i        (sysref),
        .subclass_i      (subclass),
        .lane_sync_en_i  (lane_sync_en),
        .frame_octets_i  (frame_octets),
        .hw_reinit_dis_i (hw_dis),
        .sw_reinit_req_i (sw_req),
        .lmfc_tick_i     (lmfc_tick),
        .phase_o         (phase),
        .lmfc_offset_o   (offset),
        .reinit_evt_o    (evt)
    );

    always @(posedge clk) if (!rst && evt) evt_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; sync_n = 1'b0; sysref = 1'b0; sw_req = 1'b0;
        lmfc_tick = 1'b0; hw_dis = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic pulse_ref();
        sysref = 1'b1; cyc(2); sysref = 1'b0; cyc(4);
    endtask

    task automatic sw_pulse();
        sw_req = 1'b1; cyc(1); sw_req = 1'b0;
    endtask

    task automatic to_data();
        subclass = 2'd0; lane_sync_en = 1'b0;
        do_reset();
        sync_n = 1'b1; cyc(4);
    endtask

    initial begin
        int e0;
        @(negedge clk);

        // Vector table: exit behaviour per subclass and alignment setting
        for (int i = 0; i < NV; i++) begin
            subclass = VECS[i].sc;
            lane_sync_en = VECS[i].lse;
            do_reset();
            if (i == 0) begin
                check("R1 phase", int'(phase), 0);
                check("R1 offset", int'(offset), 0);
                check("R1 evt", int'(evt), 0);
            end
            if (VECS[i].ref_pulse) pulse_ref();
            sync_n = 1'b1;
            cyc(2);
            check(VECS[i].sc == 2'd1 ? "R3 early" : "R2 early", int'(phase), 0);
            cyc(1);
            check(VECS[i].sc == 2'd1 ? "R3 exit" : "R2 exit", int'(phase), int'(VECS[i].exp_phase));
        end

        // R9: alignment lasts four multiframe pulses
        subclass = 2'd0; lane_sync_en = 1'b1;
        do_reset();
        sync_n = 1'b1; cyc(3);
        check("R9 enter", int'(phase), 1);
        for (int k = 0; k < 3; k++) begin
            lmfc_tick = 1'b1; cyc(1); lmfc_tick = 1'b0; cyc(1);
        end
        check("R9 three ticks", int'(phase), 1);
        lmfc_tick = 1'b1; cyc(1);
        check("R9 fourth tick", int'(phase), 2);
        lmfc_tick = 1'b0;

        // R5 boundary: 5*2+9 = 19 low cycles tolerated, 20 restart
        to_data();
        e0 = evt_cnt;
        sync_n = 1'b0; cyc(19); sync_n = 1'b1; cyc(6);
        check("R5 exact limit phase", int'(phase), 2);
        check("R5 exact limit evt", evt_cnt, e0);
        sync_n = 1'b0; cyc(20); cyc(6);
        check("R5 over limit", int'(phase), 0);
        check("R10 one event", evt_cnt, e0 + 1);

        // R6: split runs do not accumulate
        to_data();
        e0 = evt_cnt;
        sync_n = 1'b0; cyc(15); sync_n = 1'b1; cyc(1);
        sync_n = 1'b0; cyc(15); sync_n = 1'b1; cyc(6);
        check("R6 split runs", int'(phase), 2);
        check("R6 no event", evt_cnt, e0);

        // R7: disable blocks timing restart
        hw_dis = 1'b1;
        sync_n = 1'b0; cyc(40); sync_n = 1'b1; cyc(6);
        check("R7 phase", int'(phase), 2);
        check("R7 evt", evt_cnt, e0);

        // R8: software restart still works while disabled
        sw_pulse();
        check("R8 immediate", int'(phase), 0);
        cyc(8);
        check("R8 waits for low", int'(phase), 0);
        check("R10 sw event", evt_cnt, e0 + 1);
        sync_n = 1'b0; cyc(4); sync_n = 1'b1; cyc(4);
        check("R8 exit after low", int'(phase), 2);
        hw_dis = 1'b0;

        // R3 late reference and R11 flag cleared by restart
        subclass = 2'd1; lane_sync_en = 1'b0;
        do_reset();
        sync_n = 1'b1; cyc(8);
        check("R3 released without ref", int'(phase), 0);
        pulse_ref();
        check("R3 late ref", int'(phase), 2);
        sw_pulse();
        sync_n = 1'b0; cyc(4); sync_n = 1'b1; cyc(8);
        check("R11 needs new ref", int'(phase), 0);
        pulse_ref();
        check("R11 new ref exit", int'(phase), 2);

        // R4: offset capture in subclass 2, delay 1 and 5
        subclass = 2'd2; lane_sync_en = 1'b1;
        do_reset();
        cyc(3);
        lmfc_tick = 1'b1; cyc(1); lmfc_tick = 1'b0;
        sync_n = 1'b1; cyc(5);
        check("R4 offset d1", int'(offset), 2);
        do_reset();
        check("R1 offset cleared", int'(offset), 0);
        cyc(3);
        lmfc_tick = 1'b1; cyc(1); lmfc_tick = 1'b0;
        cyc(4);
        sync_n = 1'b1; cyc(5);
        check("R4 offset d5", int'(offset), 6);

        // R4: no capture outside subclass 2
        subclass = 2'd0;
        do_reset();
        cyc(3);
        lmfc_tick = 1'b1; cyc(1); lmfc_tick = 1'b0;
        cyc(2);
        sync_n = 1'b1; cyc(5);
        check("R4 sc0 keeps offset", int'(offset), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule